// File: doc/BRIEF.md
# Double-Buffered UART Register Front End

This block is the register-facing half of a serial port. Software sees two word registers on a simple strobe bus: a data register that takes bytes to send and returns the last byte received, and a status register with four flags. The bit-level line, baud generation and framing are outside the block. Bytes to send leave on a one-cycle valid strobe once their character time has run. Received bytes arrive on a one-cycle valid strobe from whatever deserialiser sits next to it.

Transmission is double buffered. A shift stage holds the byte currently "on the wire" and a holding stage queues one more. A down-counter of `CHAR_CYCLES` clocks models one character time. When a character ends, a queued byte moves into the shift stage and the next character time starts on the same edge, so queued bytes leave exactly `CHAR_CYCLES` apart. Each finished character and each received byte raises a one-cycle pulse on interrupt line 3 of a 16-line request vector.

The byte streams have no back-pressure in either direction. `tx_valid` is a pulse that the downstream sink must take in the cycle it is high. `rx_valid` is accepted in every cycle, and a byte that arrives before software has read the previous one is recorded as an overrun.

Top module: `uart_dbuf_regs`

## Requirements
- R1: After reset the status register reads 0x00000006 (shift-empty and holding-empty set, data-ready and overrun clear). `tx_valid` and every `irq` line are low, and the data register reads 0.
- R2: The data register is at offset 0x70 and the status register at 0x74. Status bit 0 is data-ready, bit 1 shift-empty, bit 2 holding-empty and bit 4 overrun, and every other bit reads 0. Reads of any other offset return 0, and writes to any other offset change nothing.
- R3: A data-register write while shift-empty is set loads the byte into the shift stage. Shift-empty clears, holding-empty stays set and a character time starts.
- R4: A data-register write while shift-empty is clear puts the byte in the holding stage and clears holding-empty. If the holding stage is already full, the new byte replaces the one waiting there.
- R5: A byte loaded into the shift stage on clock edge k appears on `tx_data` with `tx_valid` high for exactly one cycle, beginning at edge k+`CHAR_CYCLES`.
- R6: When a character ends with the holding stage empty, shift-empty sets. With a byte waiting, that byte enters the shift stage, holding-empty sets and the next character time starts on the same edge. A write that lands on the ending edge while the holding stage is empty goes straight into the shift stage.
- R7: A received byte is latched into the data register and sets data-ready. If data-ready was already set and the data register is not read in that same cycle, overrun also sets.
- R8: Reading the data register returns the byte in bits 7:0, with zeros above, and clears data-ready. A byte that arrives in the same cycle as the read is latched, keeps data-ready set and does not raise overrun.
- R9: A status-register write clears overrun and leaves data-ready, shift-empty and holding-empty unchanged. An overrun raised in the same cycle as the write still sets.
- R10: `irq` bit 3 is high for one cycle starting at the edge that samples `rx_valid`, and also in every cycle that `tx_valid` is high. All other `irq` bits stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read (when bus_sel is high) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write byte (the data register uses it; the status register ignores it) |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the access cycle |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle strobe: a character has finished |
| tx_data | output | 8 | The finished byte |
| irq | output | 16 | Interrupt request lines; only bit 3 is ever driven high |

## Verification
The bench aims at the edges of the transmit path. One corner is a write that arrives on the very edge where a character ends with nothing queued: a design that follows the write-goes-to-holding rule literally would leave the byte stranded behind an idle shifter and never send it. Another is a third write into a full holding stage: a design that got it wrong would send the stale byte, or send three bytes. On the receive side the bench drives a byte in the same cycle as a data read, where a wrong design flags a false overrun or loses the new byte. It also drives an overrun in the same cycle as a status write, where a wrong design clears a fault it has just seen. Exact character spacing is checked to the cycle, so an off-by-one counter shows up as a byte one edge early or late.

// File: rtl/uart_dbuf_pkg.sv
package uart_dbuf_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 8;

  // Status bit positions decoded by software
  localparam int FLAG_READY   = 0;
  localparam int FLAG_SH_IDLE = 1;
  localparam int FLAG_HD_IDLE = 2;
  localparam int FLAG_OVERRUN = 4;

  typedef struct packed {
    logic overrun;
    logic hold_idle;
    logic shift_idle;
    logic ready;
  } uart_flags_t;

  function automatic logic [WORD_W-1:0] flags_to_word(input uart_flags_t f);
    logic [WORD_W-1:0] w;
    w = '0;
    w[FLAG_READY]   = f.ready;
    w[FLAG_SH_IDLE] = f.shift_idle;
    w[FLAG_HD_IDLE] = f.hold_idle;
    w[FLAG_OVERRUN] = f.overrun;
    return w;
  endfunction
endpackage

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DATA_W      = 8,
  parameter int CHAR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  output logic              shift_idle,
  output logic              hold_idle,
  output logic              done_valid,
  output logic [DATA_W-1:0] done_byte
);
  localparam int CW = (CHAR_CYCLES > 1) ? $clog2(CHAR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CHAR_CYCLES - 1);

  logic              busy, busy_n;
  logic              hold_full, hold_full_n;
  logic [DATA_W-1:0] shreg, shreg_n;
  logic [DATA_W-1:0] hreg, hreg_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic              fin;

  assign fin = busy && (cnt == '0);

  always_comb begin
    busy_n      = busy;
    hold_full_n = hold_full;
    shreg_n     = shreg;
    hreg_n      = hreg;
    cnt_n       = cnt;
    if (fin) begin
      if (hold_full) begin
        shreg_n     = hreg;
        cnt_n       = LAST;
        hold_full_n = 1'b0;
        if (wr_en) begin
          hreg_n      = wr_byte;
          hold_full_n = 1'b1;
        end
      end else if (wr_en) begin
        shreg_n = wr_byte;
        cnt_n   = LAST;
      end else begin
        busy_n = 1'b0;
      end
    end else if (busy) begin
      cnt_n = cnt - CW'(1);
      if (wr_en) begin
        hreg_n      = wr_byte;
        hold_full_n = 1'b1;
      end
    end else if (wr_en) begin
      shreg_n = wr_byte;
      busy_n  = 1'b1;
      cnt_n   = LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      hold_full  <= 1'b0;
      shreg      <= '0;
      hreg       <= '0;
      cnt        <= '0;
      done_valid <= 1'b0;
      done_byte  <= '0;
    end else begin
      busy       <= busy_n;
      hold_full  <= hold_full_n;
      shreg      <= shreg_n;
      hreg       <= hreg_n;
      cnt        <= cnt_n;
      done_valid <= fin;
      if (fin) done_byte <= shreg;
    end
  end

  assign shift_idle = !busy;
  assign hold_idle  = !hold_full;

  // R3: a write into an idle shifter starts a character with holding left empty
  assert_load_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> (busy && !hold_full));

  // R4: a write during a running character fills the holding stage
  assert_hold_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && !fin) |=> hold_full);

  // R6: a queued byte never waits behind an idle shifter
  assert_hold_behind_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full |-> busy);

  generate
    if (CHAR_CYCLES > 1) begin : g_pulse_chk
      // R5: completion strobe lasts one cycle
      assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
    end
  endgenerate
endmodule

// File: rtl/uart_rx_latch.sv
module uart_rx_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              rd_take,
  input  logic              clr_sticky,
  output logic [DATA_W-1:0] byte_q,
  output logic              ready,
  output logic              overrun
);
  logic lost;

  assign lost = in_valid && ready && !rd_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= '0;
      ready   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (in_valid) byte_q <= in_byte;
      if (in_valid)     ready <= 1'b1;
      else if (rd_take) ready <= 1'b0;
      if (lost)            overrun <= 1'b1;
      else if (clr_sticky) overrun <= 1'b0;
    end
  end

  // R7: unread byte overwritten raises overrun
  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ready && !rd_take) |=> overrun);

  // R8: a read with no new arrival empties the register
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !in_valid) |=> !ready);

  // R9: status write drops overrun unless a new one lands that cycle
  assert_sticky_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sticky && !lost) |=> !overrun);

  // R9: status write leaves data-ready alone
  assert_ready_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sticky && ready && !rd_take) |=> ready);
endmodule

// File: rtl/uart_dbuf_regs.sv
module uart_dbuf_regs
  import uart_dbuf_pkg::*;
#(
  parameter int              CHAR_CYCLES = 1000,
  parameter int              NUM_IRQ     = 16,
  parameter int              IRQ_LVL     = 3,
  parameter logic [OFS_W-1:0] DATA_OFS   = 8'h70,
  parameter logic [OFS_W-1:0] STAT_OFS   = 8'h74
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [OFS_W-1:0]   bus_addr,
  input  logic [BYTE_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic               rx_valid,
  input  logic [BYTE_W-1:0]  rx_data,
  output logic               tx_valid,
  output logic [BYTE_W-1:0]  tx_data,
  output logic [NUM_IRQ-1:0] irq
);
  localparam int PAD_W = WORD_W - BYTE_W;

  logic              hit_data, hit_stat;
  logic              tx_wr, rx_rd, stat_wr;
  logic              sh_idle, hd_idle;
  logic              rdy, ovr;
  logic [BYTE_W-1:0] rx_q;
  logic              rx_pulse_q;
  logic              irq_pulse;
  uart_flags_t       flags;

  assign hit_data = bus_sel && (bus_addr == DATA_OFS);
  assign hit_stat = bus_sel && (bus_addr == STAT_OFS);
  assign tx_wr    = hit_data && bus_wr;
  assign rx_rd    = hit_data && !bus_wr;
  assign stat_wr  = hit_stat && bus_wr;

  uart_tx_dbuf #(.DATA_W(BYTE_W), .CHAR_CYCLES(CHAR_CYCLES)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (tx_wr),
    .wr_byte    (bus_wdata),
    .shift_idle (sh_idle),
    .hold_idle  (hd_idle),
    .done_valid (tx_valid),
    .done_byte  (tx_data)
  );

  uart_rx_latch #(.DATA_W(BYTE_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (rx_valid),
    .in_byte    (rx_data),
    .rd_take    (rx_rd),
    .clr_sticky (stat_wr),
    .byte_q     (rx_q),
    .ready      (rdy),
    .overrun    (ovr)
  );

  always_comb begin
    flags.ready      = rdy;
    flags.shift_idle = sh_idle;
    flags.hold_idle  = hd_idle;
    flags.overrun    = ovr;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_data)      bus_rdata = {{PAD_W{1'b0}}, rx_q};
    else if (hit_stat) bus_rdata = flags_to_word(flags);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_pulse_q <= 1'b0;
    else        rx_pulse_q <= rx_valid;
  end

  assign irq_pulse = rx_pulse_q || tx_valid;

  generate
    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
      if (gi == IRQ_LVL) begin : g_hit
        assign irq[gi] = irq_pulse;
      end else begin : g_idle
        assign irq[gi] = 1'b0;
      end
    end
  endgenerate

  // R10: each received byte raises the interrupt on the next cycle
  assert_rx_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> irq[IRQ_LVL]);

  // R10: each finished character raises the interrupt alongside its strobe
  assert_tx_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> irq[IRQ_LVL]);
endmodule

// File: tb/uart_dbuf_regs_bench.sv
module uart_dbuf_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 1000;
  localparam logic [7:0] A_DATA = 8'h70;
  localparam logic [7:0] A_STAT = 8'h74;
  localparam int NVEC = 10;
  // {op, byte, expected status, expected read byte}; op 0 = rx byte, 1 = data read, 2 = status write
  localparam logic [25:0] VEC [NVEC] = '{
    {2'd0, 8'h41, 8'h07, 8'h00},
    {2'd1, 8'h00, 8'h06, 8'h41},
    {2'd0, 8'h42, 8'h07, 8'h00},
    {2'd0, 8'h43, 8'h17, 8'h00},
    {2'd1, 8'h00, 8'h16, 8'h43},
    {2'd2, 8'h00, 8'h06, 8'h00},
    {2'd0, 8'h5A, 8'h07, 8'h00},
    {2'd2, 8'h00, 8'h07, 8'h00},
    {2'd1, 8'h00, 8'h06, 8'h5A},
    {2'd1, 8'h00, 8'h06, 8'h5A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic [15:0] irq;

  int n_vec = 0, n_bad = 0;
  int cyc = 0;
  int ev_n = 0;
  int ev_cyc [16];
  logic [7:0] ev_byte [16];

  uart_dbuf_regs u_uart_dbuf_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_data(tx_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // log every finished character; R10 interrupt must accompany it
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (ev_n < 16) begin
        ev_cyc[ev_n]  = cyc;
        ev_byte[ev_n] = tx_data;
      end
      ev_n++;
      chk("R10 irq with tx strobe", {16'h0, irq}, 32'h0000_0008);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  logic [31:0] rd;
  int c0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(A_STAT, rd);   chk("R1 reset status", rd, 32'h6);
    chk("R1 reset tx_valid", {31'h0, tx_valid}, 32'h0);
    chk("R1 reset irq", {16'h0, irq}, 32'h0);
    bus_read(A_DATA, rd);   chk("R1 reset data", rd, 32'h0);

    // R2 unmapped offsets
    bus_read(8'h78, rd);    chk("R2 unmapped read", rd, 32'h0);
    bus_write(8'h78, 8'hFF);
    bus_read(A_STAT, rd);   chk("R2 unmapped write ignored", rd, 32'h6);

    // receive-path vector table: R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op;
      op = VEC[i][25:24];
      case (op)
        2'd0: rx_push(VEC[i][23:16]);
        2'd1: begin
          bus_read(A_DATA, rd);
          chk($sformatf("R8 vec %0d data read", i), rd, {24'h0, VEC[i][7:0]});
        end
        default: bus_write(A_STAT, 8'h00);
      endcase
      bus_read(A_STAT, rd);
      chk($sformatf("R7/R9 vec %0d status", i), rd, {24'h0, VEC[i][15:8]});
    end

    // R10 receive interrupt timing
    rx_push(8'h11);
    chk("R10 rx irq high", {16'h0, irq}, 32'h8);
    @(negedge clk);
    chk("R10 rx irq one cycle", {16'h0, irq}, 32'h0);
    bus_read(A_DATA, rd);

    // R8 arrival in the same cycle as a data read
    rx_push(8'h21);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_DATA;
    rx_valid = 1'b1; rx_data = 8'h22;
    #1 rd = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; rx_valid = 1'b0;
    chk("R8 read returns old byte", rd, 32'h21);
    bus_read(A_STAT, rd);   chk("R8 no false overrun", rd, 32'h7);
    bus_read(A_DATA, rd);   chk("R8 new byte kept", rd, 32'h22);

    // R9 overrun in the same cycle as a status write
    rx_push(8'h31);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT;
    rx_valid = 1'b1; rx_data = 8'h32;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
    bus_read(A_STAT, rd);   chk("R9 overrun wins over clear", rd, 32'h17);
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, rd);   chk("R9 clear keeps ready", rd, 32'h7);
    bus_read(A_DATA, rd);
    wait_to(cyc + 3);

    // R3 R5 single character
    ev_n = 0;
    bus_write(A_DATA, 8'hA5);
    c0 = cyc;
    bus_read(A_STAT, rd);   chk("R3 shifter loaded", rd, 32'h4);
    wait_to(c0 + N + 3);
    chk("R5 one strobe", ev_n, 1);
    chk("R5 strobe cycle", ev_cyc[0], c0 + N);
    chk("R5 strobe byte", {24'h0, ev_byte[0]}, 32'hA5);
    bus_read(A_STAT, rd);   chk("R6 idle after single", rd, 32'h6);

    // R4 R6 queued bytes, holding overwrite
    ev_n = 0;
    bus_write(A_DATA, 8'hB1);
    c0 = cyc;
    bus_write(A_DATA, 8'hB2);
    bus_read(A_STAT, rd);   chk("R4 holding full", rd, 32'h0);
    bus_write(A_DATA, 8'hB3);
    bus_read(A_STAT, rd);   chk("R4 overwrite keeps full", rd, 32'h0);
    wait_to(c0 + N + 3);
    bus_read(A_STAT, rd);   chk("R6 holding moved", rd, 32'h4);
    wait_to(c0 + 2 * N + 3);
    chk("R4 two strobes", ev_n, 2);
    chk("R6 first cycle", ev_cyc[0], c0 + N);
    chk("R6 first byte", {24'h0, ev_byte[0]}, 32'hB1);
    chk("R6 second cycle", ev_cyc[1], c0 + 2 * N);
    chk("R4 second byte replaced", {24'h0, ev_byte[1]}, 32'hB3);
    bus_read(A_STAT, rd);   chk("R6 idle after pair", rd, 32'h6);

    // R6 write on the completion edge with empty holding
    ev_n = 0;
    bus_write(A_DATA, 8'hC1);
    c0 = cyc;
    wait_to(c0 + N - 1);
    bus_write(A_DATA, 8'hC2);
    bus_read(A_STAT, rd);   chk("R6 edge write into shifter", rd, 32'h4);
    wait_to(c0 + 2 * N + 3);
    chk("R6 edge two strobes", ev_n, 2);
    chk("R6 edge first cycle", ev_cyc[0], c0 + N);
    chk("R6 edge second cycle", ev_cyc[1], c0 + 2 * N);
    chk("R6 edge second byte", {24'h0, ev_byte[1]}, 32'hC2);
    bus_read(A_STAT, rd);   chk("R6 idle after edge case", rd, 32'h6);

    finish_run();
  end
endmodule